// File: doc/BRIEF.md
# Burst Address Adapter for AXI Width Conversion

This block sits on one AXI address channel (read or write) between a left port, where it acts as a slave, and a right port, where it acts as a master with a different data width. Each burst taken on the left is rewritten for the width of the right port. When the right port is wider (upconversion), the adapter aligns the start address to the wide word. It works out how many narrow words of padding come before the first real word and after the last one, and it sets the shortened beat count to match. When the right port is narrower (downconversion), it changes the size to the narrow width and multiplies the beat count by the width ratio. If that count is more than the right side allows, the burst is split into two.

For every left burst the adapter also sends a side record on its own valid/ready pair. The record holds the head padding, the tail padding and a split flag, and the data and response paths use it. Responses for one ID must come back in order, so the adapter counts outstanding bursts and holds back a burst with a new ID until the count falls to zero. The data path pulses a completion input to lower the count. Throttling is always on for downconversion and is a parameter for upconversion.

Top module: `burst_addr_adapter`

## Requirements
- R1: A burst is converted only when its burst type is INCR (encoding 2'b01) and its size code equals log2 of the left port width in bytes. Any other burst goes through with its address, length and size unchanged, zero padding and no split.
- R2: On upconversion, a converted burst leaves with its address rounded down to a multiple of the right width in bytes, with size code log2(right bytes) and burst type INCR.
- R3: On upconversion with ratio N = right/left, head = (addr / left bytes) mod N, right length = (head + len) / N (integer division), and tail = N - 1 - ((head + len) mod N).
- R4: On downconversion with ratio N = left/right, a converted burst leaves with its address rounded down to a multiple of the left width in bytes, size code log2(right bytes), and length (len+1)*N - 1 whenever (len+1)*N is at most MAX_BEATS. Its split flag is 0.
- R5: On downconversion, when T = (len+1)*N exceeds MAX_BEATS, the first right burst has length MAX_BEATS-1 and split flag 1. In the cycles after that, the adapter itself presents a second burst with the same ID and size, address equal to the first address + MAX_BEATS*right bytes, and length T-MAX_BEATS-1. This second burst stays stable until the right side takes it, and the left port is not ready until then.
- R6: A left burst is taken only in a cycle where both right ready and record ready are high. In that cycle right valid and record valid are both high. Right valid does not rise while record ready is low, and record valid does not rise while right ready is low.
- R7: With throttling on and at least one burst outstanding, a left burst whose ID differs from the ID of the last burst taken is not accepted. A burst with the same ID is accepted.
- R8: The outstanding count rises by one for each burst taken and falls by one for each completion pulse. A burst with a different ID is accepted once the count is back at zero. When MAX_OUT bursts are outstanding, no burst is accepted.
- R9: On upconversion with UP_THROTTLE = 0, a burst with a different ID is accepted while others are outstanding.
- R10: A synchronous active-low reset clears the outstanding count and any pending second burst. After reset, a burst with any ID is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l_valid | input | 1 | Left address valid |
| l_ready | output | 1 | Left address ready |
| l_addr | input | ADDR_W | Left burst start address |
| l_len | input | LEN_W | Left beat count minus one |
| l_size | input | 3 | Left size code (log2 bytes per beat) |
| l_burst | input | 2 | Left burst type |
| l_id | input | ID_W | Left transaction ID |
| r_valid | output | 1 | Right address valid |
| r_ready | input | 1 | Right address ready |
| r_addr | output | ADDR_W | Right burst start address |
| r_len | output | LEN_W | Right beat count minus one |
| r_size | output | 3 | Right size code |
| r_burst | output | 2 | Right burst type |
| r_id | output | ID_W | Right transaction ID |
| info_valid | output | 1 | Side record valid |
| info_ready | input | 1 | Side record ready |
| info_head | output | LEN_W | Padding words before the first real word |
| info_tail | output | LEN_W | Padding words after the last real word |
| info_split | output | 1 | Burst was split into two right bursts |
| burst_done | input | 1 | Pulse: one outstanding burst has finished |

## Verification
The hardest state to reach from the ports is the pending second half of a split burst, because the adapter drives the right channel on its own while the left port is closed. The bench reaches it with random left lengths on a narrow-side instance whose maximum is 16 beats, so about half of the bursts overflow. It also holds right ready low for several cycles to show that the second burst stays stable. The ID stall is reached by leaving bursts uncompleted on purpose and by presenting rival IDs only within the low half of the clock, so two instances that share one stimulus keep equal counts.

// File: rtl/bxa_pkg.sv
// Shared constants for the burst address adapter.
// Assumes the standard AXI burst type encoding.
package bxa_pkg;
    typedef enum logic [1:0] {
        BT_FIXED = 2'b00,
        BT_INCR  = 2'b01,
        BT_WRAP  = 2'b10
    } burst_kind_e;
endpackage

// File: rtl/bxa_shape.sv
// Combinational burst reshaper: turns one left burst into the right-port form.
// Upconversion gives head/tail padding and a shorter length. Downconversion gives
// a narrow size, a longer length and an optional second half.
// Assumes that (len+1)*ratio never exceeds 2*MAX_BEATS on downconversion.
module bxa_shape #(
    parameter int LEFT_W    = 32,
    parameter int RIGHT_W   = 64,
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 8,
    parameter int MAX_BEATS = 256
) (
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [LEN_W-1:0]  a_len,
    input  logic [2:0]        a_size,
    input  logic [1:0]        a_burst,
    output logic [ADDR_W-1:0] o_addr,
    output logic [LEN_W-1:0]  o_len,
    output logic [2:0]        o_size,
    output logic [LEN_W-1:0]  o_head,
    output logic [LEN_W-1:0]  o_tail,
    output logic              o_split,
    output logic [ADDR_W-1:0] o_addr2,
    output logic [LEN_W-1:0]  o_len2
);
    import bxa_pkg::*;

    localparam int  LB     = LEFT_W / 8;
    localparam int  RB     = RIGHT_W / 8;
    localparam int  LSIZE  = $clog2(LB);
    localparam int  RSIZE  = $clog2(RB);
    localparam bit  IS_UP  = RIGHT_W > LEFT_W;
    localparam int  RATIO  = IS_UP ? RIGHT_W / LEFT_W : LEFT_W / RIGHT_W;
    localparam int  RLOG   = $clog2(RATIO);
    localparam int  WIDE_W = LEN_W + RLOG + 1;

    logic              convert;
    logic [ADDR_W-1:0] cv_addr;
    logic [LEN_W-1:0]  cv_len;
    logic [LEN_W-1:0]  cv_head;
    logic [LEN_W-1:0]  cv_tail;
    logic              cv_split;
    logic [ADDR_W-1:0] cv_addr2;
    logic [LEN_W-1:0]  cv_len2;

    assign convert = (a_burst == BT_INCR) && (a_size == 3'(LSIZE));

    if (IS_UP) begin : gen_up
        localparam logic [LEN_W:0] MASK = (LEN_W+1)'(RATIO - 1);
        logic [LEN_W:0] head_w;
        logic [LEN_W:0] last_w;

        // Padding and length from the word position inside the wide word.
        always_comb begin
            head_w   = (LEN_W+1)'((a_addr >> LSIZE) & ADDR_W'(RATIO - 1));
            last_w   = head_w + {1'b0, a_len};
            cv_addr  = a_addr & ~ADDR_W'(RB - 1);
            cv_len   = LEN_W'(last_w >> RLOG);
            cv_head  = LEN_W'(head_w);
            cv_tail  = LEN_W'(MASK - (last_w & MASK));
            cv_split = 1'b0;
            cv_addr2 = cv_addr;
            cv_len2  = '0;
        end

        // Padding plus real words fill the right beats exactly.
        // R3
        always_comb begin
            if (convert) begin
                pad_sum_chk: assert ((32'(cv_len) + 1) * RATIO ==
                                     32'(cv_head) + 32'(a_len) + 1 + 32'(cv_tail));
            end
        end
    end else begin : gen_down
        logic [WIDE_W-1:0] total;
        logic              over;

        // Beat multiplication and split decision for a narrower right port.
        always_comb begin
            total    = (WIDE_W'(a_len) + WIDE_W'(1)) << RLOG;
            over     = total > WIDE_W'(MAX_BEATS);
            cv_addr  = a_addr & ~ADDR_W'(LB - 1);
            cv_len   = over ? LEN_W'(MAX_BEATS - 1) : LEN_W'(total - WIDE_W'(1));
            cv_head  = '0;
            cv_tail  = '0;
            cv_split = over;
            cv_addr2 = cv_addr + ADDR_W'(MAX_BEATS * RB);
            cv_len2  = LEN_W'(total - WIDE_W'(MAX_BEATS) - WIDE_W'(1));
        end

        // Both halves of a split together carry every narrow beat.
        // R5
        always_comb begin
            if (convert && over) begin
                split_len_chk: assert (32'(cv_len) + 32'(cv_len2) + 2 == 32'(total));
            end
        end
    end

    // Final choice between the converted form and plain pass-through.
    always_comb begin
        if (convert) begin
            o_addr  = cv_addr;
            o_len   = cv_len;
            o_size  = 3'(RSIZE);
            o_head  = cv_head;
            o_tail  = cv_tail;
            o_split = cv_split;
            o_addr2 = cv_addr2;
            o_len2  = cv_len2;
        end else begin
            o_addr  = a_addr;
            o_len   = a_len;
            o_size  = a_size;
            o_head  = '0;
            o_tail  = '0;
            o_split = 1'b0;
            o_addr2 = a_addr;
            o_len2  = '0;
        end
    end
endmodule

// File: rtl/bxa_gate.sv
// Outstanding-burst counter and ID throttle.
// Allows a new burst while there is room and, when throttling, while the ID matches
// the last accepted one or nothing is outstanding.
// Assumes one completion pulse per accepted burst, never more.
module bxa_gate #(
    parameter int ID_W     = 4,
    parameter int MAX_OUT  = 8,
    parameter bit THROTTLE = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic            give,
    input  logic [ID_W-1:0] cand_id,
    output logic            allow
);
    localparam int CNT_W = $clog2(MAX_OUT + 1);

    logic [CNT_W-1:0] cnt;
    logic [ID_W-1:0]  held_id;
    logic             room;
    logic             same;

    // Count accepted bursts up and completed bursts down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (take && !give) begin
            cnt <= cnt + CNT_W'(1);
        end else if (!take && give && cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Remember the ID of the most recent accepted burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_id <= '0;
        end else if (take) begin
            held_id <= cand_id;
        end
    end

    assign room = cnt != CNT_W'(MAX_OUT);

    if (THROTTLE) begin : gen_thr
        assign same = (cnt == '0) || (cand_id == held_id);

        // R7
        id_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (take && cnt != '0) |-> (cand_id == held_id));
    end else begin : gen_free
        assign same = 1'b1;
    end

    assign allow = room && same;

    // R8
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAX_OUT));
endmodule

// File: rtl/burst_addr_adapter.sv
// Burst address adapter for AXI data width conversion.
// Rewrites each left burst for the right width, emits one side record per left
// burst, issues the second half of split bursts and throttles differing IDs.
// Assumes left fields stay stable while l_valid is high and not yet accepted.
module burst_addr_adapter #(
    parameter int LEFT_W      = 32,
    parameter int RIGHT_W     = 64,
    parameter int ADDR_W      = 32,
    parameter int ID_W        = 4,
    parameter int LEN_W       = 8,
    parameter int MAX_BEATS   = 256,
    parameter int MAX_OUT     = 8,
    parameter bit UP_THROTTLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_valid,
    output logic              l_ready,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [LEN_W-1:0]  l_len,
    input  logic [2:0]        l_size,
    input  logic [1:0]        l_burst,
    input  logic [ID_W-1:0]   l_id,
    output logic              r_valid,
    input  logic              r_ready,
    output logic [ADDR_W-1:0] r_addr,
    output logic [LEN_W-1:0]  r_len,
    output logic [2:0]        r_size,
    output logic [1:0]        r_burst,
    output logic [ID_W-1:0]   r_id,
    output logic              info_valid,
    input  logic              info_ready,
    output logic [LEN_W-1:0]  info_head,
    output logic [LEN_W-1:0]  info_tail,
    output logic              info_split,
    input  logic              burst_done
);
    import bxa_pkg::*;

    localparam bit IS_UP    = RIGHT_W > LEFT_W;
    localparam bit THROTTLE = IS_UP ? UP_THROTTLE : 1'b1;

    logic [ADDR_W-1:0] s_addr, s_addr2;
    logic [LEN_W-1:0]  s_len, s_len2, s_head, s_tail;
    logic [2:0]        s_size;
    logic              s_split;
    logic              allow;
    logic              take;
    logic              pend;
    logic [ADDR_W-1:0] p_addr;
    logic [LEN_W-1:0]  p_len;
    logic [2:0]        p_size;
    logic [ID_W-1:0]   p_id;

    bxa_shape #(
        .LEFT_W(LEFT_W), .RIGHT_W(RIGHT_W), .ADDR_W(ADDR_W),
        .LEN_W(LEN_W), .MAX_BEATS(MAX_BEATS)
    ) u_shape (
        .a_addr(l_addr), .a_len(l_len), .a_size(l_size), .a_burst(l_burst),
        .o_addr(s_addr), .o_len(s_len), .o_size(s_size),
        .o_head(s_head), .o_tail(s_tail), .o_split(s_split),
        .o_addr2(s_addr2), .o_len2(s_len2)
    );

    bxa_gate #(
        .ID_W(ID_W), .MAX_OUT(MAX_OUT), .THROTTLE(THROTTLE)
    ) u_gate (
        .clk(clk), .rst_n(rst_n), .take(take), .give(burst_done),
        .cand_id(l_id), .allow(allow)
    );

    // Left handshake needs both downstream consumers; pending half blocks it.
    assign l_ready    = !pend && allow && r_ready && info_ready;
    assign take       = l_valid && l_ready;
    assign r_valid    = pend || (l_valid && allow && info_ready);
    assign info_valid = !pend && l_valid && allow && r_ready;

    assign r_addr  = pend ? p_addr : s_addr;
    assign r_len   = pend ? p_len  : s_len;
    assign r_size  = pend ? p_size : s_size;
    assign r_burst = pend ? BT_INCR : l_burst;
    assign r_id    = pend ? p_id   : l_id;

    assign info_head  = s_head;
    assign info_tail  = s_tail;
    assign info_split = s_split;

    // Track whether a second split half still awaits the right port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (take && s_split) begin
            pend <= 1'b1;
        end else if (pend && r_ready) begin
            pend <= 1'b0;
        end
    end

    // Capture the second half fields when a split burst is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_addr <= '0;
            p_len  <= '0;
            p_size <= '0;
            p_id   <= '0;
        end else if (take && s_split) begin
            p_addr <= s_addr2;
            p_len  <= s_len2;
            p_size <= s_size;
            p_id   <= l_id;
        end
    end

    // R6
    both_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_valid && l_ready) |-> (r_valid && r_ready && info_valid && info_ready));

    // R5
    split_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_valid && l_ready && info_split) |=> (r_valid && !l_ready && r_id == $past(l_id)));

    // R5
    split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !r_ready) |=> (r_valid && $stable(r_addr) && $stable(r_len)));
endmodule

// File: tb/sim_burst_addr_adapter.sv
module sim_burst_addr_adapter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int tests = 0;
    int fails = 0;

    // Shared stimulus for the two upconverting instances (u0 throttles, u2 does not).
    logic        ua_valid = 0, u_rready = 1, u_iready = 1, u_done = 0;
    logic [31:0] ua_addr = 0;
    logic [7:0]  ua_len = 0;
    logic [2:0]  ua_size = 0;
    logic [1:0]  ua_burst = 0;
    logic [3:0]  ua_id = 0;
    logic        u0_lready, u0_rvalid, u0_ivalid, u0_split;
    logic [31:0] u0_raddr;
    logic [7:0]  u0_rlen, u0_head, u0_tail;
    logic [2:0]  u0_rsize;
    logic [1:0]  u0_rburst;
    logic [3:0]  u0_rid;
    logic        u2_lready, u2_rvalid, u2_ivalid, u2_split;
    logic [31:0] u2_raddr;
    logic [7:0]  u2_rlen, u2_head, u2_tail;
    logic [2:0]  u2_rsize;
    logic [1:0]  u2_rburst;
    logic [3:0]  u2_rid;

    // Downconverting instance stimulus.
    logic        da_valid = 0, d_rready = 1, d_iready = 1, d_done = 0;
    logic [31:0] da_addr = 0;
    logic [7:0]  da_len = 0;
    logic [2:0]  da_size = 0;
    logic [1:0]  da_burst = 0;
    logic [3:0]  da_id = 0;
    logic        d_lready, d_rvalid, d_ivalid, d_split;
    logic [31:0] d_raddr;
    logic [7:0]  d_rlen, d_head, d_tail;
    logic [2:0]  d_rsize;
    logic [1:0]  d_rburst;
    logic [3:0]  d_rid;

    burst_addr_adapter #(.LEFT_W(32), .RIGHT_W(64), .MAX_OUT(4), .UP_THROTTLE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .l_valid(ua_valid), .l_ready(u0_lready),
        .l_addr(ua_addr), .l_len(ua_len), .l_size(ua_size), .l_burst(ua_burst), .l_id(ua_id),
        .r_valid(u0_rvalid), .r_ready(u_rready), .r_addr(u0_raddr), .r_len(u0_rlen),
        .r_size(u0_rsize), .r_burst(u0_rburst), .r_id(u0_rid),
        .info_valid(u0_ivalid), .info_ready(u_iready), .info_head(u0_head),
        .info_tail(u0_tail), .info_split(u0_split), .burst_done(u_done));

    burst_addr_adapter #(.LEFT_W(64), .RIGHT_W(32), .MAX_BEATS(16), .MAX_OUT(4)) u1 (
        .clk(clk), .rst_n(rst_n), .l_valid(da_valid), .l_ready(d_lready),
        .l_addr(da_addr), .l_len(da_len), .l_size(da_size), .l_burst(da_burst), .l_id(da_id),
        .r_valid(d_rvalid), .r_ready(d_rready), .r_addr(d_raddr), .r_len(d_rlen),
        .r_size(d_rsize), .r_burst(d_rburst), .r_id(d_rid),
        .info_valid(d_ivalid), .info_ready(d_iready), .info_head(d_head),
        .info_tail(d_tail), .info_split(d_split), .burst_done(d_done));

    burst_addr_adapter #(.LEFT_W(32), .RIGHT_W(64), .MAX_OUT(4), .UP_THROTTLE(1'b0)) u2 (
        .clk(clk), .rst_n(rst_n), .l_valid(ua_valid), .l_ready(u2_lready),
        .l_addr(ua_addr), .l_len(ua_len), .l_size(ua_size), .l_burst(ua_burst), .l_id(ua_id),
        .r_valid(u2_rvalid), .r_ready(u_rready), .r_addr(u2_raddr), .r_len(u2_rlen),
        .r_size(u2_rsize), .r_burst(u2_rburst), .r_id(u2_rid),
        .info_valid(u2_ivalid), .info_ready(u_iready), .info_head(u2_head),
        .info_tail(u2_tail), .info_split(u2_split), .burst_done(u_done));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic up_set(input logic [31:0] a, input logic [7:0] n, input logic [2:0] s,
                          input logic [1:0] b, input logic [3:0] id);
        @(negedge clk);
        ua_addr = a; ua_len = n; ua_size = s; ua_burst = b; ua_id = id; ua_valid = 1;
        #1;
    endtask

    task automatic up_commit();
        @(posedge clk); #1; ua_valid = 0;
    endtask

    task automatic up_release(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); u_done = 1;
            @(posedge clk); #1; u_done = 0;
        end
    endtask

    task automatic dn_set(input logic [31:0] a, input logic [7:0] n, input logic [2:0] s,
                          input logic [1:0] b, input logic [3:0] id);
        @(negedge clk);
        da_addr = a; da_len = n; da_size = s; da_burst = b; da_id = id; da_valid = 1;
        #1;
    endtask

    task automatic dn_release();
        @(negedge clk); d_done = 1;
        @(posedge clk); #1; d_done = 0;
    endtask

    // Expected upconversion values for a 4-byte left, 8-byte right port.
    function automatic logic [7:0] e_head(input logic [31:0] a);
        return 8'((a / 4) % 2);
    endfunction
    function automatic logic [7:0] e_rlen(input logic [31:0] a, input logic [7:0] n);
        return 8'((32'(e_head(a)) + 32'(n)) / 2);
    endfunction
    function automatic logic [7:0] e_tail(input logic [31:0] a, input logic [7:0] n);
        return 8'(1 - ((32'(e_head(a)) + 32'(n)) % 2));
    endfunction

    task automatic up_case(input logic [31:0] a, input logic [7:0] n);
        up_set(a, n, 3'd2, 2'b01, 4'd0);
        chk("R2 up addr", u0_raddr, a & ~32'd7);
        chk("R2 up size", u0_rsize, 3'd3);
        chk("R2 up burst", u0_rburst, 2'b01);
        chk("R3 up head", u0_head, e_head(a));
        chk("R3 up len", u0_rlen, e_rlen(a, n));
        chk("R3 up tail", u0_tail, e_tail(a, n));
        chk("R6 up ready", {u0_lready, u0_rvalid, u0_ivalid}, 3'b111);
        up_commit();
        up_release(1);
    endtask

    task automatic dn_case(input logic [31:0] a, input logic [7:0] n, input logic [3:0] id);
        int total;
        logic [31:0] base;
        total = (int'(n) + 1) * 2;
        base = a & ~32'd7;
        dn_set(a, n, 3'd3, 2'b01, id);
        chk("R4 dn addr", d_raddr, base);
        chk("R4 dn size", d_rsize, 3'd2);
        chk("R4 dn ready", {d_lready, d_rvalid, d_ivalid}, 3'b111);
        if (total <= 16) begin
            chk("R4 dn len", d_rlen, 8'(total - 1));
            chk("R4 dn split", d_split, 1'b0);
        end else begin
            chk("R5 first len", d_rlen, 8'd15);
            chk("R5 split flag", d_split, 1'b1);
        end
        @(posedge clk); #1; da_valid = 0;
        if (total > 16) begin
            chk("R5 second valid", d_rvalid, 1'b1);
            chk("R5 second addr", d_raddr, base + 32'd64);
            chk("R5 second len", d_rlen, 8'(total - 17));
            chk("R5 second id", d_rid, id);
            chk("R5 left blocked", d_lready, 1'b0);
            chk("R5 no record", d_ivalid, 1'b0);
            @(posedge clk); #1;
            chk("R5 second gone", d_rvalid, 1'b0);
        end
        dn_release();
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        chk("R10 reset no pending", d_rvalid, 1'b0);
        rst_n = 1;

        // R10 any id accepted after reset.
        up_set(32'h100, 8'd0, 3'd2, 2'b01, 4'd7);
        chk("R10 ready after reset", u0_lready, 1'b1);
        ua_valid = 0;

        // Directed alignment corners.
        up_case(32'h1004, 8'd0);
        up_case(32'h1000, 8'd0);
        up_case(32'h1004, 8'd255);
        up_case(32'h1000, 8'd255);
        for (int i = 0; i < 30; i++) up_case($urandom, 8'($urandom % 256));

        // R1 pass-through for a WRAP burst and a wrong size.
        up_set(32'h2344, 8'd3, 3'd2, 2'b10, 4'd0);
        chk("R1 wrap addr", u0_raddr, 32'h2344);
        chk("R1 wrap len", u0_rlen, 8'd3);
        chk("R1 wrap size", u0_rsize, 3'd2);
        chk("R1 wrap pads", {u0_head, u0_tail, u0_split}, 17'd0);
        ua_valid = 0;
        dn_set(32'h3004, 8'd9, 3'd2, 2'b01, 4'd0);
        chk("R1 narrow size len", d_rlen, 8'd9);
        chk("R1 narrow size addr", d_raddr, 32'h3004);
        chk("R1 narrow size split", d_split, 1'b0);
        da_valid = 0;

        // R6 each downstream ready gates the handshake.
        up_set(32'h40, 8'd1, 3'd2, 2'b01, 4'd0);
        u_rready = 0; #1;
        chk("R6 rready low", {u0_lready, u0_rvalid, u0_ivalid}, 3'b010);
        u_rready = 1; u_iready = 0; #1;
        chk("R6 iready low", {u0_lready, u0_rvalid, u0_ivalid}, 3'b001);
        u_iready = 1; ua_valid = 0;

        // R7 / R9 rival ID while one burst is outstanding.
        up_set(32'h80, 8'd0, 3'd2, 2'b01, 4'd3);
        up_commit();
        up_set(32'h80, 8'd0, 3'd2, 2'b01, 4'd5);
        chk("R7 rival id stalled", u0_lready, 1'b0);
        chk("R9 no throttle accepts", u2_lready, 1'b1);
        ua_valid = 0;
        up_set(32'h88, 8'd0, 3'd2, 2'b01, 4'd3);
        chk("R7 same id accepted", u0_lready, 1'b1);
        up_commit();
        up_release(1);
        up_set(32'h90, 8'd0, 3'd2, 2'b01, 4'd5);
        chk("R8 still outstanding", u0_lready, 1'b0);
        ua_valid = 0;
        up_release(1);
        up_set(32'h90, 8'd0, 3'd2, 2'b01, 4'd5);
        chk("R8 drained accepts", u0_lready, 1'b1);
        up_commit();
        up_release(1);

        // R8 capacity limit.
        for (int k = 0; k < 4; k++) begin
            up_set(32'hA0, 8'd0, 3'd2, 2'b01, 4'd2);
            up_commit();
        end
        up_set(32'hA0, 8'd0, 3'd2, 2'b01, 4'd2);
        chk("R8 full stalls", u0_lready, 1'b0);
        chk("R8 full stalls free", u2_lready, 1'b0);
        ua_valid = 0;
        up_release(4);

        // R10 reset clears the count.
        up_set(32'hB0, 8'd0, 3'd2, 2'b01, 4'd3);
        up_commit();
        @(negedge clk); rst_n = 0;
        @(posedge clk); #1; rst_n = 1;
        up_set(32'hB0, 8'd0, 3'd2, 2'b01, 4'd9);
        chk("R10 count cleared", u0_lready, 1'b1);
        ua_valid = 0;

        // Downconversion: boundary and random lengths.
        dn_case(32'h5000, 8'd7, 4'd1);
        dn_case(32'h5005, 8'd8, 4'd2);
        dn_case(32'h5000, 8'd15, 4'd3);
        for (int i = 0; i < 30; i++) dn_case($urandom, 8'($urandom % 16), 4'($urandom));

        // R5 second half held while right is not ready.
        dn_set(32'h7000, 8'd15, 3'd3, 2'b01, 4'd6);
        @(posedge clk); #1; da_valid = 0; d_rready = 0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk("R5 held valid", d_rvalid, 1'b1);
        chk("R5 held addr", d_raddr, 32'h7040);
        chk("R5 held len", d_rlen, 8'd15);
        d_rready = 1;
        @(posedge clk); #1;
        chk("R5 released", d_rvalid, 1'b0);
        dn_release();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2000000;
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule